// File: doc/BRIEF.md
# Security-Banked Fault Status Register

This block holds a 32-bit sticky fault status word that software sees at one address in the system control space. When the security extension is built in, the block keeps two copies of the word: one for secure accesses and one for non-secure accesses. Each bus access carries a secure flag, and that flag picks the copy. Bits [15:8] form a field that both security states share. Only the non-secure copy stores that field, so either state sees the same value.

Fault-capture logic sets bits through two per-bank set vectors. Software reads the word and clears bits by writing ones. A secure clear also clears the shared field. If hardware sets a bit in the same cycle that software clears it, the set takes priority, so no fault event is lost. A build parameter can remove the secure copy. In that build a single word serves every access, whatever the secure flag.

Top module: `fsr_banked_status`

## Requirements
- R1: After reset both copies are zero, so reads in either security state return 0.
- R2: Only word offset 0xD28 is decoded. A read at any other offset returns 0, and a write there changes neither copy.
- R3: A read at 0xD28 with the secure flag high returns the secure copy ORed with bits [15:8] of the non-secure copy. With the flag low it returns the non-secure copy.
- R4: A write at 0xD28 clears, in the copy chosen by the secure flag, each bit that is 1 in the write data (write-one-to-clear). Bits written as 0 keep their value.
- R5: A secure write at 0xD28 also clears, in the non-secure copy, each bit of [15:8] that is 1 in the write data. It leaves the non-secure bits outside [15:8] unchanged.
- R6: A non-secure write changes only the non-secure copy. It can clear the shared field directly.
- R7: A 1 on a set input sets the matching bit on the next clock edge. A set for bits [15:8] is routed to the non-secure copy, whichever set input raised it, so both states see it.
- R8: When a set and a clear reach the same bit in the same cycle, the bit ends up 1.
- R9: With the security extension disabled (SECURE_EN = 0) only one copy exists. Every access uses it regardless of the secure flag, and both set inputs set bits in it.
- R10: The read data is 0 in every cycle that is not a read access (enable low, or a write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write (clear), 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the system control space |
| bus_wdata | input | 32 | Write data; ones clear bits |
| bus_secure | input | 1 | Security attribute of the access |
| set_s | input | 32 | Fault set requests raised in secure state |
| set_ns | input | 32 | Fault set requests raised in non-secure state |
| bus_rdata | output | 32 | Read data, combinational, for the same cycle |

## Verification
The bench builds two instances side by side on the same stimulus. One has the security extension enabled, with both copies and the shared-field merge. The other has SECURE_EN = 0, which exercises the single-copy path where the secure flag and the secure set input fold into one word. Both instances use the default 0xD28 offset and the [15:8] shared field. Directed accesses reach the merge, cross-state clears, set/clear collisions and off-address writes. A random phase then compares both read ports against a behavioural model on every cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_W = 32;

    typedef logic [FSR_W-1:0] fsr_word_t;

    typedef struct packed {
        fsr_word_t ns;
        fsr_word_t s;
    } fsr_pair_t;

    function automatic fsr_word_t field_mask(input int lsb, input int msb);
        fsr_word_t m;
        m = '0;
        for (int i = 0; i < FSR_W; i++) begin
            if (i >= lsb && i <= msb) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/fsr_access_decode.sv
module fsr_access_decode
    import fsr_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD28,
    parameter int                SECURE_EN  = 1,
    parameter int                SH_LSB     = 8,
    parameter int                SH_MSB     = 15
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  fsr_word_t         bus_wdata,
    input  logic              bus_secure,
    input  fsr_word_t         set_s,
    input  fsr_word_t         set_ns,
    output fsr_pair_t         clr,
    output fsr_pair_t         set,
    output logic              rd_hit,
    output logic              rd_secure
);
    localparam fsr_word_t SHARED = field_mask(SH_LSB, SH_MSB);
    localparam bit        BANKED = (SECURE_EN != 0);

    logic hit;
    logic sec_eff;
    logic wr_hit;

    always_comb begin
        hit       = (bus_addr == REG_OFFSET);
        sec_eff   = BANKED && bus_secure;
        wr_hit    = bus_en && bus_we && hit;
        rd_hit    = bus_en && !bus_we && hit;
        rd_secure = sec_eff;

        clr = '0;
        if (wr_hit) begin
            if (sec_eff) begin
                clr.s  = bus_wdata & ~SHARED;
                clr.ns = bus_wdata & SHARED;
            end else begin
                clr.ns = bus_wdata;
            end
        end

        if (BANKED) begin
            set.s  = set_s & ~SHARED;
            set.ns = set_ns | (set_s & SHARED);
        end else begin
            set.s  = '0;
            set.ns = set_ns | set_s;
        end
    end
endmodule

// File: rtl/fsr_bank.sv
module fsr_bank
    import fsr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  fsr_word_t clr,
    input  fsr_word_t set,
    output fsr_word_t q
);
    typedef struct packed {
        fsr_word_t bits;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;
endmodule

// File: rtl/fsr_read_merge.sv
module fsr_read_merge
    import fsr_pkg::*;
#(
    parameter int SH_LSB = 8,
    parameter int SH_MSB = 15
) (
    input  logic      rd_hit,
    input  logic      rd_secure,
    input  fsr_word_t s_q,
    input  fsr_word_t ns_q,
    output fsr_word_t rdata
);
    localparam fsr_word_t SHARED = field_mask(SH_LSB, SH_MSB);

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            if (rd_secure) rdata = s_q | (ns_q & SHARED);
            else           rdata = ns_q;
        end
    end
endmodule

// File: rtl/fsr_banked_status.sv
module fsr_banked_status
    import fsr_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD28,
    parameter int                SECURE_EN  = 1,
    parameter int                SH_LSB     = 8,
    parameter int                SH_MSB     = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_secure,
    input  logic [31:0]       set_s,
    input  logic [31:0]       set_ns,
    output logic [31:0]       bus_rdata
);
    fsr_pair_t clr, set;
    fsr_word_t s_q, ns_q;
    logic      rd_hit, rd_secure;

    fsr_access_decode #(
        .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .SECURE_EN(SECURE_EN),
        .SH_LSB(SH_LSB), .SH_MSB(SH_MSB)
    ) u_dec (
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_secure(bus_secure),
        .set_s(set_s), .set_ns(set_ns),
        .clr(clr), .set(set), .rd_hit(rd_hit), .rd_secure(rd_secure)
    );

    fsr_bank u_ns (
        .clk(clk), .rst_n(rst_n), .clr(clr.ns), .set(set.ns), .q(ns_q)
    );

    generate
        if (SECURE_EN != 0) begin : g_sec
            fsr_bank u_s (
                .clk(clk), .rst_n(rst_n), .clr(clr.s), .set(set.s), .q(s_q)
            );
        end else begin : g_nosec
            assign s_q = '0;
        end
    endgenerate

    fsr_read_merge #(.SH_LSB(SH_LSB), .SH_MSB(SH_MSB)) u_rd (
        .rd_hit(rd_hit), .rd_secure(rd_secure),
        .s_q(s_q), .ns_q(ns_q), .rdata(bus_rdata)
    );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hD28,
    parameter int                SECURE_EN  = 1,
    parameter int                SH_LSB     = 8,
    parameter int                SH_MSB     = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_secure,
    input logic [31:0]       set_s,
    input logic [31:0]       set_ns,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       ns_q,
    input logic [31:0]       s_q
);
    localparam fsr_word_t SHM = field_mask(SH_LSB, SH_MSB);
    localparam bit BANKED = (SECURE_EN != 0);

    logic hit, quiet_sets;
    assign hit        = (bus_addr == REG_OFFSET);
    assign quiet_sets = (set_s == '0) && (set_ns == '0);

    a_r2_off_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !hit) |-> (bus_rdata == '0));

    a_r3_shared_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (BANKED && bus_en && !bus_we && hit && bus_secure)
            |-> ((bus_rdata & SHM) == (ns_q & SHM)));

    a_r4_ns_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && hit && !(BANKED && bus_secure) && quiet_sets)
            |=> ((ns_q & $past(bus_wdata)) == '0));

    a_r5_secure_clears_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (BANKED && bus_en && bus_we && hit && bus_secure && quiet_sets)
            |=> ((ns_q & $past(bus_wdata) & SHM) == '0));

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ns != '0) |=> ((ns_q & $past(set_ns)) == $past(set_ns)));

    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en || bus_we) |-> (bus_rdata == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_en && bus_we) && quiet_sets) |=> ($stable(ns_q) && $stable(s_q)));
endmodule

bind fsr_banked_status fsr_checker #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .SECURE_EN(SECURE_EN),
    .SH_LSB(SH_LSB), .SH_MSB(SH_MSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .set_s(set_s), .set_ns(set_ns), .bus_rdata(bus_rdata),
    .ns_q(ns_q), .s_q(s_q)
);

// File: tb/sim_fsr_banked_status.sv
`timescale 1ns/1ps
module sim_fsr_banked_status;
    localparam logic [11:0] OFF = 12'hD28;
    localparam logic [31:0] SH  = 32'h0000_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, we = 1'b0, sec = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0, ss = '0, sn = '0;
    logic [31:0] rd0, rd1;

    logic [31:0] ms = '0, mns = '0, m1 = '0;
    int total = 0, fails = 0;

    always #10 clk = ~clk;

    fsr_banked_status #(.SECURE_EN(1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_secure(sec), .set_s(ss), .set_ns(sn),
        .bus_rdata(rd0));

    fsr_banked_status #(.SECURE_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_secure(sec), .set_s(ss), .set_ns(sn),
        .bus_rdata(rd1));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic e, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic s,
                       input logic [31:0] setS, input logic [31:0] setN,
                       input string tag);
        logic [31:0] e0, e1, cs, cn, c1;
        logic hit;
        en = e; we = w; addr = a; wdata = d; sec = s; ss = setS; sn = setN;
        #5;
        hit = (a == OFF);
        e0 = 0; e1 = 0;
        if (e && !w && hit) begin
            e0 = s ? (ms | (mns & SH)) : mns;
            e1 = m1;
        end
        check(tag, rd0, e0);
        check("R9", rd1, e1);
        @(posedge clk);
        cs = 0; cn = 0; c1 = 0;
        if (e && w && hit) begin
            c1 = d;
            if (s) begin cs = d & ~SH; cn = d & SH; end
            else   cn = d;
        end
        ms  = (ms & ~cs) | (setS & ~SH);
        mns = (mns & ~cn) | setN | (setS & SH);
        m1  = (m1 & ~c1) | setN | setS;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        total++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        cyc(1, 0, OFF, 0, 1, 0, 0, "R1");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R1");
        // R7 sets, shared field from secure set lands in NS copy
        cyc(0, 0, OFF, 0, 0, 32'h00AA_0300, 32'h0000_00F1, "R10");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R7");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R7");
        // R6 non-secure clear touches NS copy only, including shared bit
        cyc(1, 1, OFF, 32'h0000_0101, 0, 0, 0, "R10");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R6");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R6");
        // R5 secure clear hits shared bit in NS copy, keeps NS low bits
        cyc(1, 1, OFF, 32'h00A0_02F0, 1, 0, 0, "R10");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R5");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R5");
        // R2 off-address write ignored and reads zero
        cyc(1, 1, 12'hD2C, 32'hFFFF_FFFF, 1, 0, 0, "R2");
        cyc(1, 0, 12'hD2C, 0, 1, 0, 0, "R2");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R2");
        // R8 set wins over clear, both banks
        cyc(1, 0, OFF, 0, 0, 32'h0002_0000, 32'h0000_0010, "R7");
        cyc(1, 1, OFF, 32'h0000_0010, 0, 0, 32'h0000_0010, "R8");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R8");
        cyc(1, 1, OFF, 32'h0002_0000, 1, 32'h0002_0000, 0, "R8");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R8");
        // R4 write-one-to-clear with zeros preserved
        cyc(1, 1, OFF, 32'h0000_0010, 1, 0, 0, "R4");
        cyc(1, 0, OFF, 0, 1, 0, 0, "R4");
        cyc(1, 0, OFF, 0, 0, 0, 0, "R3");
        // random phase, compared every cycle
        for (int i = 0; i < 600; i++) begin
            logic [31:0] rs, rn;
            rs = ($urandom_range(0, 3) == 0) ? $urandom() & $urandom() : 0;
            rn = ($urandom_range(0, 3) == 0) ? $urandom() & $urandom() : 0;
            cyc($urandom_range(0, 4) != 0, $urandom_range(0, 2) == 0,
                ($urandom_range(0, 7) == 0) ? 12'(($urandom() & 12'hFFC)) : OFF,
                $urandom(), $urandom_range(0, 1) == 1, rs, rn, "R4");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule